// File: doc/BRIEF.md
# LCD Line-Fetch DMA Master

This block fills an LCD line buffer with one display line of pixel data from display memory each time a line-start strobe arrives. When a strobe is accepted it takes a snapshot of the line configuration: start address, segment count, colour-mode code, memory kind and SRAM wait count. From that snapshot it works out how many memory accesses the line needs. It then raises a bus request and waits for the grant. From the grant until the last access it holds the CPU stalled, because the line fetch has priority over the processor.

Access pacing and per-line setup overhead depend on the memory kind. A 16-bit external SRAM access takes two clocks plus the programmed wait count. A 16-bit SDRAM access takes one clock, with eight clocks of setup before the first access. Internal RAM moves 32 bits per clock, with one clock of setup. The CPU stall per line is therefore deterministic. The block measures it and reports it beside the measured line-start period, so the stall ratio can be formed as stall cycles divided by period cycles.

Top module: `lcd_line_dma`

## Requirements
- R1: An accepted line start raises `bus_req` on the next cycle. No memory access and no stall occur until the clock edge at which `bus_ack` is sampled high while requesting.
- R2: `cpu_stall` is high from the cycle after the grant edge through the cycle of the last buffer write. `mem_rd` is high only while `cpu_stall` and `bus_req` are high. The total number of stalled cycles equals setup overhead plus accesses times access period.
- R3: The access count is ceil(segments × K / access bits). K is selected by `cfg_mode`: 0→1, 1→2, 2→4, 3→8, 4→12, 5→16, and 6 or 7→24. Exactly that many buffer writes are made.
- R4: For `cfg_mem` 0 or 3 (16-bit SRAM), each access is 16 bits wide and lasts 2 + `cfg_wait` cycles, with no setup overhead.
- R5: For `cfg_mem` 1 (16-bit SDRAM), each access is 16 bits wide and lasts 1 cycle. It is preceded by 8 stalled setup cycles with `mem_rd` low.
- R6: For `cfg_mem` 2 (internal RAM), each access is 32 bits wide and lasts 1 cycle. It is preceded by 1 stalled setup cycle.
- R7: On the n-th buffer write (n from 0), `mem_addr` = start address + n × access bytes (2 or 4, modulo 2^ADDR_W), `buf_addr` = n, and `buf_wdata` = `mem_rdata`.
- R8: `bus_req` falls on the cycle after the last buffer write. It rises again only after a new accepted line start.
- R9: All configuration inputs are captured at the accepted line start. Changes to them during a line do not affect that line's addresses, count or timing.
- R10: A line start that arrives while a line is requested or running sets `underrun`, which stays set until reset. Otherwise that strobe is ignored: the running line keeps its access count and ends normally.
- R11: `stall_cycles` holds the number of stalled cycles of the most recently completed line. It updates on the cycle after the last buffer write.
- R12: `line_period` holds the number of cycles between the two most recent line-start strobes, accepted or not. It is visible the cycle after the strobe.
- R13: A line whose access count is zero raises no request and sets `stall_cycles` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle strobe starting a line fetch |
| cfg_base | input | ADDR_W | Byte start address of the line in display memory |
| cfg_segs | input | SEG_W | Number of pixels (segments) in the line |
| cfg_mode | input | 3 | Colour-mode code selecting bits per pixel |
| cfg_mem | input | 2 | Memory kind: 0/3 SRAM16, 1 SDRAM16, 2 internal RAM |
| cfg_wait | input | WAIT_W | Extra wait cycles per SRAM access |
| bus_req | output | 1 | Bus request to the CPU side |
| bus_ack | input | 1 | Bus grant from the CPU side |
| cpu_stall | output | 1 | High while the CPU is held off |
| mem_rd | output | 1 | Memory read active |
| mem_addr | output | ADDR_W | Byte address of the current access |
| mem_rdata | input | 32 | Read data (lower 16 bits used for 16-bit memories) |
| buf_we | output | 1 | Line buffer write strobe, one per access |
| buf_addr | output | SEG_W+2 | Line buffer word index |
| buf_wdata | output | 32 | Line buffer write data |
| stall_cycles | output | STALL_W | Stalled cycles of the last completed line |
| line_period | output | PER_W | Cycles between the last two line starts |
| underrun | output | 1 | Sticky flag: a line start arrived while busy |

## Verification
The bench drives inputs on falling edges and samples on falling edges. A strobe driven at one falling edge is registered at the next rising edge, so `bus_req`, `line_period` and `underrun` are checked one falling edge later. After the grant is driven, stall cycles are counted from the next falling edge until the first falling edge where `cpu_stall` is low. At that same edge the released `bus_req` and the published `stall_cycles` are both due. Setup overhead is counted as stalled edges before the first `mem_rd`, and addresses and data are compared on every edge where `buf_we` is high.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;

   typedef enum logic [1:0] {
      MEM_SRAM16     = 2'd0,
      MEM_SDRAM16    = 2'd1,
      MEM_IRAM32     = 2'd2,
      MEM_SRAM16_ALT = 2'd3
   } mem_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RUN  = 2'd2
   } dma_state_e;

   localparam int PACE_W      = 8;
   localparam int OVH_W       = 4;
   localparam int SDRAM_SETUP = 8;
   localparam int IRAM_SETUP  = 1;
   localparam int SRAM_BASE   = 2;

   typedef struct packed {
      logic [PACE_W-1:0] pace;
      logic [OVH_W-1:0]  ovh;
      logic              wide;
   } acc_timing_t;

   function automatic logic [4:0] bpp_of(input logic [2:0] code);
      case (code)
         3'd0:    bpp_of = 5'd1;
         3'd1:    bpp_of = 5'd2;
         3'd2:    bpp_of = 5'd4;
         3'd3:    bpp_of = 5'd8;
         3'd4:    bpp_of = 5'd12;
         3'd5:    bpp_of = 5'd16;
         default: bpp_of = 5'd24;
      endcase
   endfunction

endpackage

// File: rtl/ldma_line_plan.sv
module ldma_line_plan
   import lcd_dma_pkg::*;
#(
   parameter int SEG_W     = 10,
   parameter int WAIT_W    = 4,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [2:0]        mode,
   input  logic [1:0]        mem,
   input  logic [WAIT_W-1:0] wait_cnt,
   output logic [SEG_W+1:0]  n_acc,
   output acc_timing_t       timing
);
   localparam int PROD_W = SEG_W + 5;
   localparam int N_W    = SEG_W + 2;

   if (WAIT_W < 1 || WAIT_W > 6) begin : g_bad_wait
      $error("ldma_line_plan: WAIT_W must lie in 1..6");
   end

   logic [PROD_W-1:0] bits;

   if (SHIFT_ADD) begin : g_shift_add
      logic [2:0] sh_a;
      logic [2:0] sh_b;
      logic       use_b;
      always_comb begin
         sh_a  = 3'd0;
         sh_b  = 3'd0;
         use_b = 1'b0;
         case (mode)
            3'd0: sh_a = 3'd0;
            3'd1: sh_a = 3'd1;
            3'd2: sh_a = 3'd2;
            3'd3: sh_a = 3'd3;
            3'd4: begin sh_a = 3'd3; sh_b = 3'd2; use_b = 1'b1; end
            3'd5: sh_a = 3'd4;
            default: begin sh_a = 3'd4; sh_b = 3'd3; use_b = 1'b1; end
         endcase
      end
      assign bits = (PROD_W'(seg) << sh_a)
                  + (use_b ? (PROD_W'(seg) << sh_b) : '0);
   end else begin : g_multiply
      assign bits = PROD_W'(seg) * PROD_W'(bpp_of(mode));
   end

   logic [PROD_W:0] rounded;
   logic            wide;

   always_comb begin
      wide    = (mem == MEM_IRAM32);
      rounded = {1'b0, bits} + (wide ? (PROD_W+1)'(31) : (PROD_W+1)'(15));
      n_acc   = wide ? N_W'(rounded >> 5) : N_W'(rounded >> 4);
   end

   always_comb begin
      timing = '0;
      case (mem)
         MEM_SDRAM16: begin
            timing.pace = PACE_W'(1);
            timing.ovh  = OVH_W'(SDRAM_SETUP);
            timing.wide = 1'b0;
         end
         MEM_IRAM32: begin
            timing.pace = PACE_W'(1);
            timing.ovh  = OVH_W'(IRAM_SETUP);
            timing.wide = 1'b1;
         end
         default: begin
            timing.pace = PACE_W'(SRAM_BASE) + PACE_W'(wait_cnt);
            timing.ovh  = '0;
            timing.wide = 1'b0;
         end
      endcase
   end

   always_comb begin
      assert (timing.pace != '0);  // R4
   end

endmodule

// File: rtl/ldma_pacer.sv
module ldma_pacer
   import lcd_dma_pkg::*;
#(
   parameter int N_W = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [N_W-1:0] n_total,
   input  acc_timing_t    timing,
   output logic           in_ovh,
   output logic           in_xfer,
   output logic           beat,
   output logic           last_beat,
   output logic [N_W-1:0] idx
);
   logic [OVH_W-1:0]  ovh_left;
   logic [PACE_W-1:0] cyc;

   assign beat      = in_xfer && (cyc == timing.pace - PACE_W'(1));
   assign last_beat = beat && (idx == n_total - N_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_ovh   <= 1'b0;
         in_xfer  <= 1'b0;
         ovh_left <= '0;
         cyc      <= '0;
         idx      <= '0;
      end else if (start) begin
         idx <= '0;
         cyc <= '0;
         if (timing.ovh != '0) begin
            in_ovh   <= 1'b1;
            ovh_left <= timing.ovh;
         end else begin
            in_xfer <= 1'b1;
         end
      end else if (in_ovh) begin
         if (ovh_left == OVH_W'(1)) begin
            in_ovh  <= 1'b0;
            in_xfer <= 1'b1;
         end else begin
            ovh_left <= ovh_left - OVH_W'(1);
         end
      end else if (in_xfer) begin
         if (beat) begin
            cyc <= '0;
            if (last_beat) in_xfer <= 1'b0;
            else           idx     <= idx + N_W'(1);
         end else begin
            cyc <= cyc + PACE_W'(1);
         end
      end
   end

   AST_XFER_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      in_xfer |-> (idx < n_total));  // R3
   AST_SETUP_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(in_xfer) && timing.ovh != '0) |-> $past(in_ovh));  // R5
   AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ovh && in_xfer));  // R2

endmodule

// File: rtl/ldma_stall_meter.sv
module ldma_stall_meter #(
   parameter int STALL_W = 16,
   parameter int PER_W   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_strobe,
   input  logic               accept,
   input  logic               zero_line,
   input  logic               stall_active,
   input  logic               finish,
   output logic [STALL_W-1:0] stall_cycles,
   output logic [PER_W-1:0]   line_period
);
   logic [STALL_W-1:0] run_cnt;
   logic [PER_W-1:0]   per_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_cnt      <= '0;
         stall_cycles <= '0;
      end else begin
         if (accept)            run_cnt <= '0;
         else if (stall_active) run_cnt <= run_cnt + STALL_W'(1);
         if (finish)         stall_cycles <= run_cnt + STALL_W'(1);
         else if (zero_line) stall_cycles <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_cnt     <= '0;
         line_period <= '0;
      end else if (line_strobe) begin
         line_period <= per_cnt;
         per_cnt     <= PER_W'(1);
      end else if (per_cnt != '1) begin
         per_cnt <= per_cnt + PER_W'(1);
      end
   end

   AST_STALL_PUBLISH_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stall_cycles) |-> $past(finish || zero_line));  // R11
   AST_PERIOD_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(line_period) |-> $past(line_strobe));  // R12

endmodule

// File: rtl/lcd_line_dma.sv
module lcd_line_dma
   import lcd_dma_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SEG_W     = 10,
   parameter int WAIT_W    = 4,
   parameter int STALL_W   = 16,
   parameter int PER_W     = 16,
   parameter bit SHIFT_ADD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_start,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [SEG_W-1:0]   cfg_segs,
   input  logic [2:0]         cfg_mode,
   input  logic [1:0]         cfg_mem,
   input  logic [WAIT_W-1:0]  cfg_wait,
   output logic               bus_req,
   input  logic               bus_ack,
   output logic               cpu_stall,
   output logic               mem_rd,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [31:0]        mem_rdata,
   output logic               buf_we,
   output logic [SEG_W+1:0]   buf_addr,
   output logic [31:0]        buf_wdata,
   output logic [STALL_W-1:0] stall_cycles,
   output logic [PER_W-1:0]   line_period,
   output logic               underrun
);
   localparam int N_W       = SEG_W + 2;
   localparam int MAX_N     = ((2**SEG_W - 1) * 24 + 15) / 16;
   localparam int MAX_STALL = SDRAM_SETUP + MAX_N * (SRAM_BASE + 2**WAIT_W - 1);

   if (SEG_W < 1 || SEG_W > 20) begin : g_bad_seg
      $error("lcd_line_dma: SEG_W must lie in 1..20");
   end
   if (ADDR_W < N_W + 2) begin : g_bad_addr
      $error("lcd_line_dma: ADDR_W too narrow for a full line");
   end
   if ($clog2(MAX_STALL + 1) > STALL_W) begin : g_bad_stall
      $error("lcd_line_dma: STALL_W cannot hold the longest line stall");
   end
   if (PER_W < 2) begin : g_bad_per
      $error("lcd_line_dma: PER_W must be at least 2");
   end

   dma_state_e        state;
   logic [ADDR_W-1:0] base_q;
   logic [N_W-1:0]    n_q;
   acc_timing_t       tim_q;

   logic [N_W-1:0]    plan_n;
   acc_timing_t       plan_tim;

   ldma_line_plan #(
      .SEG_W     (SEG_W),
      .WAIT_W    (WAIT_W),
      .SHIFT_ADD (SHIFT_ADD)
   ) u_plan (
      .seg      (cfg_segs),
      .mode     (cfg_mode),
      .mem      (cfg_mem),
      .wait_cnt (cfg_wait),
      .n_acc    (plan_n),
      .timing   (plan_tim)
   );

   logic accept, zero_line, grant_edge;
   logic in_ovh, in_xfer, beat, last_beat;
   logic [N_W-1:0] idx;

   assign accept     = line_start && (state == ST_IDLE);
   assign zero_line  = accept && (plan_n == '0);
   assign grant_edge = (state == ST_REQ) && bus_ack;

   ldma_pacer #(.N_W(N_W)) u_pacer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (grant_edge),
      .n_total   (n_q),
      .timing    (tim_q),
      .in_ovh    (in_ovh),
      .in_xfer   (in_xfer),
      .beat      (beat),
      .last_beat (last_beat),
      .idx       (idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         base_q <= '0;
         n_q    <= '0;
         tim_q  <= '0;
      end else begin
         case (state)
            ST_IDLE: if (accept && !zero_line) begin
               base_q <= cfg_base;
               n_q    <= plan_n;
               tim_q  <= plan_tim;
               state  <= ST_REQ;
            end
            ST_REQ:  if (bus_ack)   state <= ST_RUN;
            ST_RUN:  if (last_beat) state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                underrun <= 1'b0;
      else if (line_start && state != ST_IDLE)   underrun <= 1'b1;
   end

   logic [ADDR_W-1:0] step_off;

   if (ADDR_W > N_W + 2) begin : g_off_pad
      assign step_off = tim_q.wide ? {{(ADDR_W-N_W-2){1'b0}}, idx, 2'b00}
                                   : {{(ADDR_W-N_W-1){1'b0}}, idx, 1'b0};
   end else begin : g_off_exact
      assign step_off = tim_q.wide ? {idx, 2'b00}
                                   : {1'b0, idx, 1'b0};
   end

   assign bus_req   = (state != ST_IDLE);
   assign cpu_stall = (state == ST_RUN);
   assign mem_rd    = in_xfer;
   assign mem_addr  = base_q + step_off;
   assign buf_we    = beat;
   assign buf_addr  = idx;
   assign buf_wdata = mem_rdata;

   ldma_stall_meter #(
      .STALL_W (STALL_W),
      .PER_W   (PER_W)
   ) u_meter (
      .clk          (clk),
      .rst_n        (rst_n),
      .line_strobe  (line_start),
      .accept       (accept),
      .zero_line    (zero_line),
      .stall_active (cpu_stall),
      .finish       (last_beat),
      .stall_cycles (stall_cycles),
      .line_period  (line_period)
   );

   AST_READ_ONLY_WHEN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (bus_req && cpu_stall));  // R2
   AST_STALL_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> ($past(bus_ack) && $past(bus_req)));  // R1
   AST_STALL_MATCHES_PACER: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_stall == (in_ovh || in_xfer));  // R2
   AST_RELEASE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && last_beat) |=> !bus_req);  // R8
   AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_req) |-> $past(line_start));  // R8
   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun);  // R10

endmodule

// File: tb/lcd_line_dma_bench.sv
module lcd_line_dma_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W  = 24;
   localparam int SEG_W   = 10;
   localparam int WAIT_W  = 4;
   localparam int STALL_W = 16;
   localparam int PER_W   = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               line_start = 1'b0;
   logic [ADDR_W-1:0]  cfg_base = '0;
   logic [SEG_W-1:0]   cfg_segs = '0;
   logic [2:0]         cfg_mode = '0;
   logic [1:0]         cfg_mem = '0;
   logic [WAIT_W-1:0]  cfg_wait = '0;
   logic               bus_req, bus_ack = 1'b0, cpu_stall, mem_rd, buf_we, underrun;
   logic [ADDR_W-1:0]  mem_addr;
   logic [31:0]        mem_rdata, buf_wdata;
   logic [SEG_W+1:0]   buf_addr;
   logic [STALL_W-1:0] stall_cycles;
   logic [PER_W-1:0]   line_period;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_strobe = 0;
   int n_strobes = 0;
   int exp_period = 0;
   bit done_flag = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] data_of(input logic [ADDR_W-1:0] a);
      return {a[7:0], ~a[7:0], a[15:0]};
   endfunction
   assign mem_rdata = data_of(mem_addr);

   lcd_line_dma #(
      .ADDR_W(ADDR_W), .SEG_W(SEG_W), .WAIT_W(WAIT_W),
      .STALL_W(STALL_W), .PER_W(PER_W), .SHIFT_ADD(1'b1)
   ) u_lcd_line_dma (
      .clk(clk), .rst_n(rst_n), .line_start(line_start),
      .cfg_base(cfg_base), .cfg_segs(cfg_segs), .cfg_mode(cfg_mode),
      .cfg_mem(cfg_mem), .cfg_wait(cfg_wait),
      .bus_req(bus_req), .bus_ack(bus_ack), .cpu_stall(cpu_stall),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .stall_cycles(stall_cycles), .line_period(line_period),
      .underrun(underrun)
   );

   function automatic int k_of(input int m);
      case (m)
         0: return 1;  1: return 2;  2: return 4;  3: return 8;
         4: return 12; 5: return 16; default: return 24;
      endcase
   endfunction
   function automatic int acc_bits(input int mt); return (mt == 2) ? 32 : 16; endfunction
   function automatic int n_of(input int seg, input int m, input int mt);
      return (seg * k_of(m) + acc_bits(mt) - 1) / acc_bits(mt);
   endfunction
   function automatic int pace_of(input int mt, input int w);
      return (mt == 1 || mt == 2) ? 1 : 2 + w;
   endfunction
   function automatic int ovh_of(input int mt);
      return (mt == 1) ? 8 : ((mt == 2) ? 1 : 0);
   endfunction
   function automatic string type_tag(input int mt);
      return (mt == 1) ? "R5" : ((mt == 2) ? "R6" : "R4");
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic note_strobe();
      if (n_strobes > 0) exp_period = cyc - last_strobe;
      last_strobe = cyc;
      n_strobes++;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   task automatic run_line(input int seg, input int m, input int mt, input int w,
                           input logic [ADDR_W-1:0] base, input int ack_delay,
                           input bit inject);
      int n, p, o, total, stalls, beats, pre, addr_bad, it, bad_act, bad_exp;
      bit early, injected, step_is_four;
      n = n_of(seg, m, mt);
      p = pace_of(mt, w);
      o = ovh_of(mt);
      total = o + n * p;
      @(negedge clk);
      cfg_segs = SEG_W'(seg); cfg_mode = 3'(m); cfg_mem = 2'(mt);
      cfg_wait = WAIT_W'(w); cfg_base = base;
      line_start = 1'b1;
      note_strobe();
      @(negedge clk);
      line_start = 1'b0;
      if (n_strobes > 1)
         chk(line_period == PER_W'(exp_period), "R12", "line period", line_period, exp_period);
      if (n == 0) begin
         chk(!bus_req, "R13", "no request for empty line", bus_req, 0);
         chk(stall_cycles == 0, "R13", "stall of empty line", stall_cycles, 0);
         return;
      end
      chk(bus_req && !cpu_stall, "R1", "request raised, not yet stalled", {bus_req, cpu_stall}, 2);
      early = 1'b0;
      for (int d = 0; d < ack_delay; d++) begin
         @(negedge clk);
         if (mem_rd || cpu_stall || !bus_req) early = 1'b1;
      end
      chk(!early, "R1", "no transfer before grant", early, 0);
      bus_ack = 1'b1;
      stalls = 0; beats = 0; pre = 0; addr_bad = 0; it = 0; injected = 1'b0;
      bad_act = 0; bad_exp = 0;
      step_is_four = (mt == 2);
      forever begin
         @(negedge clk);
         it++;
         if (line_start) line_start = 1'b0;
         if (it == 2) begin
            cfg_segs = SEG_W'($urandom); cfg_mode = 3'($urandom);
            cfg_mem = 2'($urandom); cfg_wait = WAIT_W'($urandom);
            cfg_base = ADDR_W'($urandom);
         end
         if (cpu_stall) begin
            stalls++;
            if (!mem_rd && beats == 0) pre++;
            if (buf_we) begin
               logic [ADDR_W-1:0] ea;
               ea = base + ADDR_W'(beats * (step_is_four ? 4 : 2));
               if (mem_addr != ea || buf_addr != (SEG_W+2)'(beats) || buf_wdata != data_of(ea)) begin
                  if (addr_bad == 0) begin bad_act = int'(mem_addr); bad_exp = int'(ea); end
                  addr_bad++;
               end
               beats++;
            end
            if (inject && it == 3) begin
               line_start = 1'b1;
               note_strobe();
               injected = 1'b1;
            end
         end else if (stalls > 0 || it > 20) begin
            break;
         end
         if (it > 40000) break;
      end
      chk(!bus_req, "R8", "request released after last write", bus_req, 0);
      chk(stalls == total, type_tag(mt), "stalled cycles (overhead + accesses*pace)", stalls, total);
      chk(beats == n, "R3", "buffer writes", beats, n);
      chk(pre == o, type_tag(mt), "setup cycles before first read", pre, o);
      chk(addr_bad == 0, "R7", "address/data of writes (first bad addr)", bad_act, bad_exp);
      chk(stall_cycles == STALL_W'(total), "R11", "published stall count", stall_cycles, total);
      if (it >= 2)
         chk(beats == n && stalls == total, "R9", "mid-line config change ignored", beats, n);
      if (injected) begin
         chk(underrun, "R10", "underrun set by busy strobe", underrun, 1);
         chk(line_period == PER_W'(exp_period), "R12", "period after busy strobe", line_period, exp_period);
      end
      bus_ack = 1'b0;
      for (int g = 0; g < 3; g++) begin
         @(negedge clk);
         chk(!bus_req, "R8", "no request between lines", bus_req, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240517));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!bus_req && !cpu_stall && !mem_rd && !buf_we, "R1", "reset outputs idle", bus_req, 0);
      chk(stall_cycles == 0 && line_period == 0, "R11", "reset counters", stall_cycles, 0);
      chk(!underrun, "R10", "underrun clear at reset", underrun, 0);

      run_line(1, 0, 0, 0, 24'h000100, 0, 1'b0);
      run_line(0, 5, 1, 0, 24'h000200, 0, 1'b0);
      run_line(5, 4, 2, 0, 24'h000300, 2, 1'b0);
      chk(!underrun, "R10", "no underrun on clean lines", underrun, 0);
      run_line(33, 1, 3, 3, 24'hFFFFF0, 4, 1'b0);
      run_line(1023, 6, 1, 0, 24'h123456, 1, 1'b1);
      run_line(7, 7, 0, 15, 24'h000401, 0, 1'b0);
      for (int i = 0; i < 30; i++) begin
         int seg, m, mt, w, tot;
         seg = $urandom_range(0, 160);
         m   = $urandom_range(0, 7);
         mt  = $urandom_range(0, 3);
         w   = $urandom_range(0, 3);
         tot = ovh_of(mt) + n_of(seg, m, mt) * pace_of(mt, w);
         run_line(seg, m, mt, w, ADDR_W'($urandom), $urandom_range(0, 5),
                  (tot >= 12) && ($urandom_range(0, 1) == 1));
      end
      chk(underrun, "R10", "underrun stays set", underrun, 1);
      finish_run();
   end
endmodule